// File: doc/BRIEF.md
# Dual-Channel DAC Load Controller

This block is the digital side of two 12-bit voltage DAC channels. It sits between a 16-bit register port and the code inputs of the analog cores. Each channel has a control word and a right-justified data word. The block turns the stored data into a 12-bit core code according to the channel's width and number format. It also decides when that code is applied: on a data write, on a rising edge of one of two timer outputs, or jointly with the next channel up once both data words have been written. Each update raises a flag, which can drive an interrupt, and gives a one-cycle DMA request pulse.

Register address: bit 1 selects the channel and bit 0 selects the word (0 = control, 1 = data). Control word layout:

| Bits | Field |
|------|-------|
| [1:0] | load source |
| [2] | enable |
| [3] | group |
| [4] | 8-bit mode |
| [5] | two's complement |
| [8:6] | buffer setting |
| [9] | interrupt enable |
| [10] | update flag |
| [11] | calibration busy |
| [15:12] | always zero |

A channel's calibration request holds off its updates for a fixed number of cycles. Buffer settings are passed to the analog side as decoded control outputs.

Top module: `dac_ld_top`

## Requirements
- R1: After a synchronous reset, both codes, both control words, both data words, the interrupt outputs and the DMA outputs are zero. Both channels report a high-impedance output, because buffer setting 000 is the reset value.
- R2: A data word keeps bits [11:0] of what is written, and reads back with bits [15:12] always zero.
- R3: In 12-bit mode (control bit 4 = 0) the code equals the data word in straight binary. In two's complement (control bit 5 = 1) the code is the data word with bit 11 inverted.
- R4: In 8-bit mode (control bit 4 = 1) data bits [7:0] form code bits [11:4], and code bits [3:0] are zero. Data bits [11:8] have no effect. In two's complement, data bit 7 is inverted.
- R5: With load source 0 the code takes the new data one clock edge after the edge that captures the write, whatever the enable bit holds.
- R6: With load source 2 (timer A) or 3 (timer B) each rising edge of the selected input, after synchronisation, gives exactly one update, and only while enable is 1. The other timer input, and edges seen while enable is 0, leave the code unchanged.
- R7: Load source 1 with the group bit set on channel 0 updates both channels on the same edge, and only after both data words have been written since the last joint update. The written marks then clear. Channel 1's group bit is ignored and reads 0.
- R8: Every update sets the flag (control bit 10). A control write with bit 10 = 0 clears the flag, but an update in the same cycle wins. The interrupt output is the flag ANDed with control bit 9.
- R9: The DMA request of a channel is high for exactly one cycle, the cycle in which the new code first appears.
- R10: Buffer setting 000 asserts the high-impedance output and setting 001 asserts the grounded output. Settings 010 to 111 assert neither.
- R11: Writing control bit 11 = 1 makes it read 1 for CAL_CYCLES cycles, after which it clears itself. No update happens while it is set. A load-source-0 data write made during that time is applied once it clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | register clock |
| rst | input | 1 | synchronous active-high reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 2 | write address (channel, word) |
| reg_wdata | input | 16 | write data |
| rd_addr | input | 2 | read address (channel, word) |
| rd_data | output | 16 | read data, combinational |
| tmr_a | input | 1 | asynchronous timer A output |
| tmr_b | input | 1 | asynchronous timer B output |
| code0 | output | 12 | core code, channel 0 |
| code1 | output | 12 | core code, channel 1 |
| out_hiz | output | 2 | per channel: output off, high impedance |
| out_gnd | output | 2 | per channel: output off, forced to 0 V |
| irq | output | 2 | per channel interrupt request |
| dma_req | output | 2 | per channel one-cycle DMA request |

## Verification
An update taken by a channel and a control write that clears that channel's flag can land on the same clock edge. The bench provokes this by writing a load-source-0 data word and, in the very next cycle, writing the control word with the flag bit at 0. It then reads the flag back as 1 and sees the interrupt still high. It also checks that a later, lone control write does clear the flag.

// File: rtl/dac_ld_pkg.sv
package dac_ld_pkg;

    localparam int NUM_CH   = 2;
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int ADDR_W   = CH_W + 1;
    localparam int REG_W    = 16;
    localparam int CODE_W   = 12;
    localparam int NARROW_W = 8;
    localparam int CTL_W    = 12;
    localparam int AMP_W    = 3;

    localparam logic [AMP_W-1:0] AMP_OFF_HIZ = 3'd0;
    localparam logic [AMP_W-1:0] AMP_OFF_GND = 3'd1;

    typedef enum logic [1:0] {
        LD_WRITE = 2'd0,
        LD_GROUP = 2'd1,
        LD_TMR_A = 2'd2,
        LD_TMR_B = 2'd3
    } load_src_e;

    // Packed from bit 11 down to bit 0.
    typedef struct packed {
        logic             cal;
        logic             flag;
        logic             ie;
        logic [AMP_W-1:0] amp;
        logic             twos;
        logic             res8;
        logic             grp;
        logic             en;
        load_src_e        lsel;
    } ctl_t;

    // Turns a stored data word into the offset-binary code for the core.
    function automatic logic [CODE_W-1:0] norm_code(
        input logic [CODE_W-1:0] raw,
        input logic              res8,
        input logic              twos
    );
        logic [NARROW_W-1:0] nb;
        logic [CODE_W-1:0]   wb;
        nb = raw[NARROW_W-1:0];
        nb[NARROW_W-1] = nb[NARROW_W-1] ^ twos;
        wb = raw;
        wb[CODE_W-1] = wb[CODE_W-1] ^ twos;
        return res8 ? {nb, {(CODE_W-NARROW_W){1'b0}}} : wb;
    endfunction

endpackage

// File: rtl/dac_ld_trig_sync.sv
module dac_ld_trig_sync #(
    parameter int N_TRIG = 2,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TRIG-1:0] trig_async,
    output logic [N_TRIG-1:0] rise
);
    localparam int DEPTH = STAGES + 1;

    for (genvar i = 0; i < N_TRIG; i++) begin : g_trig
        logic [DEPTH-1:0] sh;

        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[DEPTH-2:0], trig_async[i]};
        end

        assign rise[i] = sh[DEPTH-2] & ~sh[DEPTH-1];

        // R6
        trig_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
            rise[i] |=> !rise[i]);
    end
endmodule

// File: rtl/dac_ld_channel.sv
module dac_ld_channel
    import dac_ld_pkg::*;
#(
    parameter bit HAS_PARTNER = 1'b1,
    parameter int CAL_CYCLES  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic              dat_we,
    input  logic [CTL_W-1:0]  wdata,
    input  logic              latch_evt,
    input  logic              rise_a,
    input  logic              rise_b,
    output ctl_t              ctl_view,
    output logic [CODE_W-1:0] dat_q,
    output logic [CODE_W-1:0] code,
    output logic              wr_flag,
    output logic              cal_busy,
    output logic              take,
    output logic              dma_req,
    output logic              irq
);
    localparam int CNT_W = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CAL_CYCLES - 1);

    ctl_t             ctl_r;
    ctl_t             ctl_in;
    logic [CNT_W-1:0] cal_cnt;
    logic             wr_pulse;
    logic             pend;
    logic             trig_hit;
    logic             write_go;

    always_comb begin
        ctl_in     = ctl_t'(wdata);
        ctl_in.cal = 1'b0;
        if (!HAS_PARTNER) ctl_in.grp = 1'b0;
    end

    always_comb begin
        case (ctl_r.lsel)
            LD_GROUP: trig_hit = latch_evt;
            LD_TMR_A: trig_hit = rise_a;
            LD_TMR_B: trig_hit = rise_b;
            default:  trig_hit = 1'b0;
        endcase
    end

    assign write_go = (ctl_r.lsel == LD_WRITE) && (wr_pulse || pend) && !cal_busy;
    assign take     = write_go ||
                      ((ctl_r.lsel != LD_WRITE) && ctl_r.en && trig_hit && !cal_busy);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_r    <= '0;
            cal_busy <= 1'b0;
            cal_cnt  <= '0;
            dat_q    <= '0;
            code     <= '0;
            wr_pulse <= 1'b0;
            pend     <= 1'b0;
            wr_flag  <= 1'b0;
            dma_req  <= 1'b0;
        end else begin
            if (ctl_we) ctl_r <= ctl_in;
            ctl_r.flag <= take | (ctl_we ? wdata[10] : ctl_r.flag);

            if (cal_busy) begin
                if (cal_cnt == '0) cal_busy <= 1'b0;
                else               cal_cnt  <= cal_cnt - 1'b1;
            end else if (ctl_we && wdata[11]) begin
                cal_busy <= 1'b1;
                cal_cnt  <= CNT_TOP;
            end

            if (dat_we) dat_q <= wdata;
            wr_pulse <= dat_we;

            if (take)                      pend <= 1'b0;
            else if (wr_pulse && cal_busy) pend <= 1'b1;

            if (dat_we)         wr_flag <= 1'b1;
            else if (latch_evt) wr_flag <= 1'b0;

            if (take) code <= norm_code(dat_q, ctl_r.res8, ctl_r.twos);
            dma_req <= take;
        end
    end

    always_comb begin
        ctl_view     = ctl_r;
        ctl_view.cal = cal_busy;
    end

    assign irq = ctl_r.flag & ctl_r.ie;

    // R11
    cal_blocks_load_chk: assert property (@(posedge clk) disable iff (rst)
        cal_busy |-> !take);

    // R6
    enable_gates_load_chk: assert property (@(posedge clk) disable iff (rst)
        (take && (ctl_r.lsel != LD_WRITE)) |-> ctl_r.en);

    // R8
    flag_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> ctl_r.flag);

    // R5
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(code));
endmodule

// File: rtl/dac_ld_top.sv
module dac_ld_top
    import dac_ld_pkg::*;
#(
    parameter int CAL_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              tmr_a,
    input  logic              tmr_b,
    output logic [CODE_W-1:0] code0,
    output logic [CODE_W-1:0] code1,
    output logic [NUM_CH-1:0] out_hiz,
    output logic [NUM_CH-1:0] out_gnd,
    output logic [NUM_CH-1:0] irq,
    output logic [NUM_CH-1:0] dma_req
);
    ctl_t              ctl_v  [NUM_CH];
    logic [CODE_W-1:0] dat_v  [NUM_CH];
    logic [CODE_W-1:0] code_v [NUM_CH];
    logic [NUM_CH-1:0] wf, busy, take, evt, pair_ok, pair_dn, grp_dn;
    logic [NUM_CH-1:0] ctl_we, dat_we;
    logic [1:0]        rise;
    logic [CH_W-1:0]   rd_ch;

    dac_ld_trig_sync #(.N_TRIG(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst        (rst),
        .trig_async ({tmr_b, tmr_a}),
        .rise       (rise)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ctl_we[c] = reg_we && (reg_addr[ADDR_W-1:1] == CH_W'(c)) && !reg_addr[0];
        assign dat_we[c] = reg_we && (reg_addr[ADDR_W-1:1] == CH_W'(c)) &&  reg_addr[0];

        if (c < NUM_CH - 1) begin : g_up
            assign pair_ok[c] = wf[c] & wf[c+1] & ~busy[c] & ~busy[c+1];
        end else begin : g_top
            assign pair_ok[c] = 1'b0;
        end

        if (c > 0) begin : g_dn
            assign grp_dn[c]  = ctl_v[c-1].grp;
            assign pair_dn[c] = pair_ok[c-1];
        end else begin : g_bot
            assign grp_dn[c]  = 1'b0;
            assign pair_dn[c] = 1'b0;
        end

        assign evt[c] = ctl_v[c].grp ? pair_ok[c] :
                        grp_dn[c]    ? pair_dn[c] : (wf[c] & ~busy[c]);

        dac_ld_channel #(
            .HAS_PARTNER (c < NUM_CH - 1),
            .CAL_CYCLES  (CAL_CYCLES)
        ) chan_i (
            .clk       (clk),
            .rst       (rst),
            .ctl_we    (ctl_we[c]),
            .dat_we    (dat_we[c]),
            .wdata     (reg_wdata[CTL_W-1:0]),
            .latch_evt (evt[c]),
            .rise_a    (rise[0]),
            .rise_b    (rise[1]),
            .ctl_view  (ctl_v[c]),
            .dat_q     (dat_v[c]),
            .code      (code_v[c]),
            .wr_flag   (wf[c]),
            .cal_busy  (busy[c]),
            .take      (take[c]),
            .dma_req   (dma_req[c]),
            .irq       (irq[c])
        );

        assign out_hiz[c] = (ctl_v[c].amp == AMP_OFF_HIZ);
        assign out_gnd[c] = (ctl_v[c].amp == AMP_OFF_GND);
    end

    assign code0 = code_v[0];
    assign code1 = code_v[1];

    always_comb begin
        rd_ch = rd_addr[ADDR_W-1:1];
        if (rd_addr[0]) rd_data = REG_W'(dat_v[rd_ch]);
        else            rd_data = REG_W'(ctl_v[rd_ch]);
    end

    // R7
    group_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_v[0].grp && (ctl_v[0].lsel == LD_GROUP) && take[0]) |-> (wf[0] && wf[1]));
endmodule

// File: tb/dac_ld_top_tb_top.sv
`timescale 1ns/1ps
module dac_ld_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [1:0]  rd_addr;
    logic [15:0] rd_data;
    logic        tmr_a, tmr_b;
    logic [11:0] code0, code1;
    logic [1:0]  out_hiz, out_gnd, irq, dma_req;

    int checks = 0;
    int errors = 0;
    logic [11:0] q0[$];
    logic [11:0] q1[$];
    logic [11:0] e0, e1;
    logic [15:0] v;

    always #2.5 clk = ~clk;

    dac_ld_top #(.CAL_CYCLES(16)) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .tmr_a(tmr_a), .tmr_b(tmr_b), .code0(code0), .code1(code1),
        .out_hiz(out_hiz), .out_gnd(out_gnd), .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] val);
        rd_addr = a;
        #1;
        val = rd_data;
    endtask

    // Scoreboard monitor: every DMA pulse must match the next expected code.
    always @(negedge clk) begin
        if (!rst) begin
            if (dma_req[0]) begin
                checks++;
                if (q0.size() == 0) begin
                    errors++;
                    $display("FAIL R9 ch0 unexpected update actual=%h expected=none", code0);
                end else begin
                    e0 = q0.pop_front();
                    if (code0 !== e0) begin
                        errors++;
                        $display("FAIL R3 ch0 code actual=%h expected=%h", code0, e0);
                    end
                end
            end
            if (dma_req[1]) begin
                checks++;
                if (q1.size() == 0) begin
                    errors++;
                    $display("FAIL R9 ch1 unexpected update actual=%h expected=none", code1);
                end else begin
                    e1 = q1.pop_front();
                    if (code1 !== e1) begin
                        errors++;
                        $display("FAIL R6 ch1 code actual=%h expected=%h", code1, e1);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        reg_we = 0; reg_addr = 0; reg_wdata = 0; rd_addr = 0; tmr_a = 0; tmr_b = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 code0", {4'h0, code0}, 16'h0);
        chk("R1 code1", {4'h0, code1}, 16'h0);
        chk("R1 irq/dma", {12'h0, irq, dma_req}, 16'h0);
        chk("R1 hiz", {14'h0, out_hiz}, 16'h3);
        rd(2'd0, v); chk("R1 ctl0", v, 16'h0);
        rd(2'd3, v); chk("R1 dat1", v, 16'h0);

        // R5 / R2 write-triggered, 12-bit binary, enable clear
        wr(2'd0, 16'h02C0);
        q0.push_back(12'hABC);
        wr(2'd1, 16'hFABC);
        rd(2'd1, v); chk("R2 dat0 upper bits", v, 16'h0ABC);
        repeat (2) @(negedge clk);
        chk("R5 code0 after write", {4'h0, code0}, 16'h0ABC);
        chk("R8 irq0 set", {15'h0, irq[0]}, 16'h1);

        // R3 two's complement, 12-bit
        wr(2'd0, 16'h02E0);
        q0.push_back(12'h000); wr(2'd1, 16'h0800); repeat (2) @(negedge clk);
        q0.push_back(12'hFFF); wr(2'd1, 16'h07FF); repeat (2) @(negedge clk);
        chk("R3 twos 7FF", {4'h0, code0}, 16'h0FFF);

        // R4 8-bit modes
        wr(2'd0, 16'h02D0);
        q0.push_back(12'hA50); wr(2'd1, 16'h00A5); repeat (2) @(negedge clk);
        q0.push_back(12'hC50); wr(2'd1, 16'h03C5);
        rd(2'd1, v); chk("R2 dat0 keeps 12 bits", v, 16'h03C5);
        repeat (2) @(negedge clk);
        chk("R4 8-bit binary", {4'h0, code0}, 16'h0C50);
        wr(2'd0, 16'h02F0);
        q0.push_back(12'h000); wr(2'd1, 16'h0080); repeat (2) @(negedge clk);
        q0.push_back(12'hFF0); wr(2'd1, 16'h007F); repeat (2) @(negedge clk);
        chk("R4 8-bit twos", {4'h0, code0}, 16'h0FF0);

        // R8 collision: update and flag-clearing control write in one cycle
        wr(2'd0, 16'h02C0);
        chk("R8 flag cleared", {15'h0, irq[0]}, 16'h0);
        q0.push_back(12'h055);
        wr(2'd1, 16'h0055);
        wr(2'd0, 16'h02C0);
        chk("R9 dma high", {15'h0, dma_req[0]}, 16'h1);
        @(negedge clk);
        chk("R9 dma one cycle", {15'h0, dma_req[0]}, 16'h0);
        rd(2'd0, v); chk("R8 update wins", v, 16'h06C0);
        chk("R8 irq kept", {15'h0, irq[0]}, 16'h1);
        wr(2'd0, 16'h02C0);
        rd(2'd0, v); chk("R8 lone clear", v, 16'h02C0);
        chk("R8 irq low", {15'h0, irq[0]}, 16'h0);

        // R6 timer A, enable clear then set
        wr(2'd2, 16'h00C2);
        wr(2'd3, 16'h03FF);
        repeat (3) @(negedge clk);
        chk("R6 mode2 ignores write", {4'h0, code1}, 16'h0);
        tmr_a = 1; repeat (3) @(negedge clk); tmr_a = 0;
        repeat (8) @(negedge clk);
        chk("R6 en=0 no load", {4'h0, code1}, 16'h0);
        wr(2'd2, 16'h00C6);
        q1.push_back(12'h3FF);
        tmr_a = 1; repeat (12) @(negedge clk); tmr_a = 0;
        repeat (6) @(negedge clk);
        chk("R6 timer A load", {4'h0, code1}, 16'h03FF);
        tmr_b = 1; repeat (4) @(negedge clk); tmr_b = 0;
        repeat (8) @(negedge clk);
        chk("R6 timer B ignored", {4'h0, code1}, 16'h03FF);

        // R6 timer B
        wr(2'd2, 16'h00C7);
        wr(2'd3, 16'h08F0);
        repeat (3) @(negedge clk);
        chk("R6 mode3 ignores write", {4'h0, code1}, 16'h03FF);
        q1.push_back(12'h8F0);
        tmr_b = 1; repeat (5) @(negedge clk); tmr_b = 0;
        repeat (8) @(negedge clk);
        chk("R6 timer B load", {4'h0, code1}, 16'h08F0);

        // R10 buffer settings
        wr(2'd2, 16'h0047);
        chk("R10 gnd ch1", {14'h0, out_gnd[1], out_hiz[1]}, 16'h2);
        wr(2'd2, 16'h0007);
        chk("R10 hiz ch1", {14'h0, out_gnd[1], out_hiz[1]}, 16'h1);
        chk("R10 ch0 active", {14'h0, out_gnd[0], out_hiz[0]}, 16'h0);

        // R7 grouped update
        wr(2'd0, 16'h00CD);
        wr(2'd2, 16'h00CD);
        rd(2'd2, v); chk("R7 ch1 group bit ignored", v, 16'h00C5);
        wr(2'd1, 16'h0123);
        repeat (5) @(negedge clk);
        chk("R7 waits for partner", {4'h0, code0}, 16'h0055);
        q0.push_back(12'h123); q1.push_back(12'h456);
        wr(2'd3, 16'h0456);
        repeat (3) @(negedge clk);
        chk("R7 joint ch0", {4'h0, code0}, 16'h0123);
        chk("R7 joint ch1", {4'h0, code1}, 16'h0456);
        wr(2'd3, 16'h0111);
        repeat (5) @(negedge clk);
        chk("R7 marks cleared", {4'h0, code1}, 16'h0456);
        q0.push_back(12'h222); q1.push_back(12'h111);
        wr(2'd1, 16'h0222);
        repeat (3) @(negedge clk);
        chk("R7 second joint", {4'h0, code1}, 16'h0111);

        // R11 calibration holds a write
        wr(2'd0, 16'h02C0);
        wr(2'd0, 16'h0AC0);
        rd(2'd0, v); chk("R11 cal busy", v, 16'h0AC0);
        wr(2'd1, 16'h09AB);
        repeat (8) @(negedge clk);
        chk("R11 write held", {4'h0, code0}, 16'h0222);
        q0.push_back(12'h9AB);
        repeat (14) @(negedge clk);
        rd(2'd0, v); chk("R11 cal done, flag set", v, 16'h06C0);
        chk("R11 held write applied", {4'h0, code0}, 16'h09AB);

        repeat (4) @(negedge clk);
        chk("R9 ch0 all updates seen", 16'(q0.size()), 16'h0);
        chk("R9 ch1 all updates seen", 16'(q1.size()), 16'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule